// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block drives two free-running clock outputs from a small control register. The first output is the bus clock divided by a programmable integer ratio from 1 to 32. An optional divide-by-16 stage can follow that ratio. The second output passes a reference input that runs at twice the bus clock. Each output has its own active-high disable bit.

An emulation-mode input overrides the register. While it is high, both outputs run and the divided output runs at the bus rate.

The register interface has two addresses:
- **Control address (0):** written and read back in one bus cycle.
- **Reserved address (1):** always reads zero and ignores writes.

Every change to an output enable takes effect only while that output is low, so no shortened pulse is ever emitted. Every control write restarts the divider so that the new ratio takes effect cleanly.

Top module: `clkout_divider`

## Requirements
- R1: After reset the control register reads 0x00. The divided output then toggles at the bus-clock rate (period 1 bus cycle, half a cycle high), and the double-rate output follows the reference.
- R2: A write with `reg_addr`=0 stores all 8 bits of `reg_wdata` into the control register. A read with `reg_addr`=0 returns the stored value on `reg_rdata` in the same cycle.
- R3: Reads with `reg_addr`=1 always return 0x00. Writes with `reg_addr`=1 leave the control register unchanged.
- R4: Control bits 4:0 hold the value N-1 for a divide ratio N from 1 to 32. With bit 5 clear:
  - For N=1, the divided output follows the bus clock.
  - For N≥2, the divided output has a period of N bus cycles. It is high for floor(N/2) cycles and low for the remaining cycles.
- R5: With control bit 5 set, the divided output has a period of 16·N bus cycles and is high for 8·N of them. This holds for every N, including N=1.
- R6: Control bit 7 set holds the divided output low; clearing it lets the output run again. The output is enabled or disabled only while it is low, so the first pulse after enabling is full width.
- R7: Control bit 6 set holds the double-rate output low. Bit 6 has no effect on the divided output.
- R8: While `emu_mode` is high, both outputs run, whatever control bits 7 and 6 hold.
- R9: While `emu_mode` is high, the divided output runs at the bus-clock rate, whatever control bits 5:0 hold.
- R10: A control write restarts the divider. The divided output rises on the first bus edge after the write edge. From there the output follows the new ratio with no leftover count from the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the divider counts its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_mode | input | 1 | Emulation override, synchronous to `clk` |
| x2_ref | input | 1 | Reference clock at twice the bus rate |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 reserved |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| div_clk_out | output | 1 | Gated divided clock output |
| x2_clk_out | output | 1 | Gated double-rate clock output |

## Verification
The bench measures the period and the high time of the divided output for all 32 ratios, with and without the divide-by-16 stage. It therefore catches an off-by-one ratio, a wrong duty split for odd ratios, and a dead output at ratio 1, where the output must come from the clock itself rather than from the counter.

It also covers the following cases:
- **Restart:** it samples the output edge by edge after a ratio change. A divider that ignores the restart keeps its old count and drifts from the expected cycle.
- **Reserved address:** it confirms that the reserved address leaves the control value untouched.
- **Disable and re-enable:** it checks that a disabled output stays flat, and that the first pulse after re-enabling is full width, not a runt.
- **Emulation:** it checks that emulation forces both outputs on at the bus rate even when both disables and the divide-by-16 stage are set.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int unsigned RATIO_W  = 5;
    localparam int unsigned CFG_W    = RATIO_W + 3;
    localparam int unsigned POST_DIV = 16;
    localparam int unsigned POST_W   = $clog2(POST_DIV);
    localparam int unsigned ADDR_W   = 1;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);

    typedef struct packed {
        logic               div_off;
        logic               x2_off;
        logic               post_en;
        logic [RATIO_W-1:0] ratio_m1;
    } ctrl_t;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  rdata,
    output ctrl_t             ctrl,
    output logic              restart
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  restart;
    } reg_st_t;

    reg_st_t s_d, s_q;

    // Next-state logic: a control write stores the data and arms a restart.
    always_comb begin
        s_d         = s_q;
        s_d.restart = 1'b0;
        if (we && addr == CTRL_ADDR) begin
            s_d.ctrl    = ctrl_t'(wdata);
            s_d.restart = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Any address other than the control address reads as zero.
    always_comb begin
        if (addr == CTRL_ADDR) rdata = s_q.ctrl;
        else                   rdata = '0;
    end

    assign ctrl    = s_q.ctrl;
    assign restart = s_q.restart;

    p_wr_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == CTRL_ADDR) |=> (s_q.ctrl == $past(wdata)));

    p_rsv_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr != CTRL_ADDR) |=> $stable(s_q.ctrl));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               bypass,
    input  logic               en_want,
    input  logic               post_en,
    input  logic [RATIO_W-1:0] ratio_m1,
    output logic               div_q
);
    typedef struct packed {
        logic [RATIO_W-1:0] c1;
        logic [POST_W-1:0]  c2;
        logic               out;
    } cnt_t;

    cnt_t             s_d, s_q;
    logic [RATIO_W:0] half_w;
    logic             tick;
    logic             raw_d;

    always_comb begin
        // High time of a plain-divider period: floor(N/2) with N = ratio_m1 + 1.
        half_w = ({1'b0, ratio_m1} + (RATIO_W + 1)'(1)) >> 1;
        s_d    = s_q;
        tick   = (s_q.c1 == ratio_m1);

        if (restart || bypass) begin
            s_d.c1 = '0;
            s_d.c2 = '0;
        end else if (tick) begin
            s_d.c1 = '0;
            if (post_en)
                s_d.c2 = (s_q.c2 == POST_W'(POST_DIV - 1)) ? '0 : s_q.c2 + POST_W'(1);
            else
                s_d.c2 = '0;
        end else begin
            s_d.c1 = s_q.c1 + RATIO_W'(1);
        end

        if (post_en) raw_d = (s_d.c2 < POST_W'(POST_DIV / 2));
        else         raw_d = ({1'b0, s_d.c1} < half_w);

        // The enable is taken only while the output is low; a high pulse always completes.
        s_d.out = raw_d & (s_q.out | en_want) & ~bypass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign div_q = s_q.out;

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (s_q.c1 <= ratio_m1));

    p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_want && !s_q.out) |=> !s_q.out);

    p_bypass_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (!s_q.out && s_q.c1 == '0 && s_q.c2 == '0));

    p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.c1 == '0 && s_q.c2 == '0));
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
    input  logic clk_in,
    input  logic rst_n,
    input  logic en,
    output logic clk_out
);
    logic en_d, en_q;

    always_comb en_d = en;

    // Enable is sampled while the clock is low, so the AND below cannot glitch.
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign clk_out = clk_in & en_q;
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emu_mode,
    input  logic              x2_ref,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CFG_W-1:0]  reg_wdata,
    output logic [CFG_W-1:0]  reg_rdata,
    output logic              div_clk_out,
    output logic              x2_clk_out
);
    ctrl_t ctrl;
    logic  restart;
    logic  bypass;
    logic  div_en;
    logic  x2_en;
    logic  div_q;
    logic  bus_gated;

    clkdiv_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .ctrl    (ctrl),
        .restart (restart)
    );

    // Unit ratio cannot come from a bus-edge counter, so the clock itself is gated instead.
    assign bypass = emu_mode | (ctrl.ratio_m1 == '0 && !ctrl.post_en);
    assign div_en = emu_mode | ~ctrl.div_off;
    assign x2_en  = emu_mode | ~ctrl.x2_off;

    clkdiv_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .bypass   (bypass),
        .en_want  (div_en),
        .post_en  (ctrl.post_en),
        .ratio_m1 (ctrl.ratio_m1),
        .div_q    (div_q)
    );

    clkdiv_gate u_bus_gate (
        .clk_in  (clk),
        .rst_n   (rst_n),
        .en      (bypass & div_en),
        .clk_out (bus_gated)
    );

    clkdiv_gate u_x2_gate (
        .clk_in  (x2_ref),
        .rst_n   (rst_n),
        .en      (x2_en),
        .clk_out (x2_clk_out)
    );

    assign div_clk_out = bus_gated | div_q;
endmodule

// File: tb/clkout_divider_test.sv
`timescale 1ns/1ps
module clkout_divider_test;
    logic       clk = 1'b0;
    logic       x2_ref = 1'b0;
    logic       rst_n = 1'b0;
    logic       emu = 1'b0;
    logic       we = 1'b0;
    logic [0:0] addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       div_out;
    logic       x2_out;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    clkout_divider uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .emu_mode    (emu),
        .x2_ref      (x2_ref),
        .reg_we      (we),
        .reg_addr    (addr),
        .reg_wdata   (wdata),
        .reg_rdata   (rdata),
        .div_clk_out (div_out),
        .x2_clk_out  (x2_out)
    );

    always #10 clk = ~clk;
    initial begin
        #2.5;
        forever #5 x2_ref = ~x2_ref;
    end

    task automatic chk_val(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_time(input string req, input string what, input real act, input real exp);
        checks++;
        if (act - exp > 0.01 || exp - act > 0.01) begin
            fails++;
            $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
        addr = 1'b0;
    endtask

    task automatic meas_div(input string req, input real per, input real hi);
        realtime t0, t1, t2;
        @(posedge div_out);
        @(posedge div_out); t0 = $realtime;
        @(negedge div_out); t1 = $realtime;
        @(posedge div_out); t2 = $realtime;
        chk_time(req, "div period", t2 - t0, per);
        chk_time(req, "div high", t1 - t0, hi);
    endtask

    task automatic meas_x2(input string req);
        realtime t0, t1, t2;
        @(posedge x2_out);
        @(posedge x2_out); t0 = $realtime;
        @(negedge x2_out); t1 = $realtime;
        @(posedge x2_out); t2 = $realtime;
        chk_time(req, "x2 period", t2 - t0, 10.0);
        chk_time(req, "x2 high", t1 - t0, 5.0);
    endtask

    task automatic chk_low(input string req, input bit use_div, input int cycles);
        int bad = 0;
        for (int i = 0; i < cycles * 8; i++) begin
            #2.5;
            if ((use_div ? div_out : x2_out) !== 1'b0) bad++;
        end
        chk_val(req, use_div ? "div held low, high samples" : "x2 held low, high samples", bad, 0);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        rd(1'b0, v);
        chk_val("R1", "ctrl after reset", v, 8'h00);
        meas_div("R1", 20.0, 10.0);
        meas_x2("R1");
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr(1'b0, 8'h5A); rd(1'b0, v);
        chk_val("R2", "readback 0x5A", v, 8'h5A);
        wr(1'b0, 8'h3C); rd(1'b0, v);
        chk_val("R2", "readback 0x3C", v, 8'h3C);
        wr(1'b1, 8'hFF); rd(1'b1, v);
        chk_val("R3", "reserved read", v, 8'h00);
        rd(1'b0, v);
        chk_val("R3", "ctrl after reserved write", v, 8'h3C);
    endtask

    // R4 and R5: every ratio, without and with the divide-by-16 stage.
    task automatic t_sweep;
        for (int n = 1; n <= 32; n++) begin
            for (int d = 0; d < 2; d++) begin
                real per, hi;
                wr(1'b0, {2'b00, d[0], 5'(n - 1)});
                if (d == 1) begin
                    per = 20.0 * 16 * n; hi = 20.0 * 8 * n;
                end else if (n == 1) begin
                    per = 20.0; hi = 10.0;
                end else begin
                    per = 20.0 * n; hi = 20.0 * (n / 2);
                end
                meas_div(d == 1 ? "R5" : "R4", per, hi);
            end
        end
    endtask

    task automatic t_restart;
        wr(1'b0, 8'h02);
        repeat (7) @(posedge clk);
        wr(1'b0, 8'h07);
        @(posedge clk); #5 chk_val("R10", "out at write+1", div_out, 1);
        repeat (3) @(posedge clk);
        #5 chk_val("R10", "out at write+4", div_out, 1);
        @(posedge clk); #5 chk_val("R10", "out at write+5", div_out, 0);
        repeat (4) @(posedge clk);
        #5 chk_val("R10", "out at write+9", div_out, 1);
    endtask

    task automatic t_disable;
        wr(1'b0, 8'h47);
        repeat (3) @(posedge clk);
        chk_low("R7", 1'b0, 30);
        meas_div("R7", 160.0, 80.0);
        wr(1'b0, 8'h87);
        repeat (10) @(posedge clk);
        chk_low("R6", 1'b1, 40);
        meas_x2("R6");
        wr(1'b0, 8'h07);
        @(posedge clk); #5 chk_val("R6", "first pulse start", div_out, 1);
        repeat (3) @(posedge clk);
        #5 chk_val("R6", "first pulse full width", div_out, 1);
        @(posedge clk); #5 chk_val("R6", "first pulse end", div_out, 0);
    endtask

    task automatic t_emu;
        wr(1'b0, 8'hE5);
        repeat (3) @(posedge clk);
        chk_low("R6", 1'b1, 20);
        chk_low("R7", 1'b0, 20);
        @(posedge clk); #5 emu = 1'b1;
        repeat (3) @(posedge clk);
        meas_div("R9", 20.0, 10.0);
        meas_x2("R8");
        wr(1'b0, 8'h1F);
        repeat (3) @(posedge clk);
        meas_div("R9", 20.0, 10.0);
        wr(1'b0, 8'hC0);
        repeat (3) @(posedge clk);
        meas_div("R8", 20.0, 10.0);
        wr(1'b0, 8'hE5);
        @(posedge clk); #5 emu = 1'b0;
        repeat (3) @(posedge clk);
        chk_low("R8", 1'b1, 20);
        chk_low("R8", 1'b0, 20);
        wr(1'b0, 8'h05);
        meas_div("R4", 120.0, 60.0);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_sweep();
        t_restart();
        t_disable();
        t_emu();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule